// File: doc/BRIEF.md
# Process Image Shadow Synchronizer

This block gives one processing core a private snapshot of a window of shared global variables. The core sees the snapshot as a small local store indexed from 0 to DEPTH-1. A pulse on `cycle_start` makes the block fetch every word of the window from global memory into the local store. Between phases the core reads and writes only the local store, so values changed in global memory by other cores stay invisible until the next fetch. A pulse on `cycle_end` makes the block write back to global memory only the entries the core changed since the last fetch.

Global memory is reached through a request/acknowledge port facing an arbiter. The block raises `gm_req` with address, direction and write data, holds everything steady until `gm_ack`, and moves the data in the acknowledge cycle. It then drops the request for at least one cycle. The core port uses valid/ready. A core access is taken on a clock edge where `core_valid` and `core_ready` are both high. `core_ready` is low for as long as a fetch or write-back runs, and the core must hold its request steady until it is taken. Read data is combinational from `core_idx` and is meaningful in the cycle the read is taken.

Top module: `pimg_sync`

## Requirements
- R1: After reset, `busy`, `done` and `gm_req` are low and `core_ready` is high.
- R2: A `cycle_start` pulse while idle fetches all DEPTH entries, as reads (`gm_we`=0), in ascending address order GBASE+0 up to GBASE+DEPTH-1. Each entry takes the `gm_rdata` value present in its acknowledge cycle.
- R3: `gm_req` stays high, with `gm_addr`, `gm_we` and `gm_wdata` unchanged, until `gm_ack` arrives. In the cycle after an acknowledge, `gm_req` is low.
- R4: `busy` is high and `core_ready` is low from the cycle after the triggering pulse until the phase completes. Completion gives a `done` pulse one cycle wide, and `busy` falls in that same cycle. `gm_req` is only ever high while `busy` is high.
- R5: An accepted core write stores `core_wdata` at entry `core_idx`. An accepted core read returns the stored value of that entry.
- R6: A change made to global memory after a fetch is not seen by core reads until the next fetch.
- R7: A `cycle_end` pulse while idle writes back, with `gm_we`=1, in ascending index order, exactly the entries written by the core since the last completed fetch. Each write carries the entry's stored value to address GBASE+index.
- R8: A `cycle_end` with no modified entries issues no request at all and still finishes with a `done` pulse.
- R9: The record of modified entries is cleared when a fetch completes. Entries written before that fetch are not written back at the next `cycle_end`.
- R10: `cycle_start` and `cycle_end` pulses that arrive while `busy` is high are ignored. If both arrive together while idle, only the fetch runs.
- R11: A core write presented during a fetch is held off until the fetch ends. It then lands with its own value, and the fetched value does not replace it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Pulse: begin copy-in of the window |
| cycle_end | input | 1 | Pulse: begin write-back of modified entries |
| busy | output | 1 | A fetch or write-back phase is running |
| done | output | 1 | One-cycle pulse when a phase finishes |
| core_valid | input | 1 | Core access request |
| core_ready | output | 1 | Core access can be taken this cycle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_idx | input | IDXW | Entry index within the window |
| core_wdata | input | DW | Core write data |
| core_rdata | output | DW | Value of the entry at `core_idx` |
| gm_req | output | 1 | Global memory request |
| gm_ack | input | 1 | Arbiter acknowledge, one cycle wide |
| gm_we | output | 1 | Direction of the global transfer, 1 = write |
| gm_addr | output | AW | Global memory address |
| gm_wdata | output | DW | Write-back data |
| gm_rdata | input | DW | Fetched data, valid with `gm_ack` |

## Verification
The hardest case to reach is a core write that is already waiting while a fetch is still moving words in. Its value must survive the fetch, and the next write-back must carry that write alone. The bench issues the write in the cycle right after `cycle_start`, while the arbiter model adds varying acknowledge delays that stretch the fetch. It then checks the stored value and the exact write-back traffic. A `cycle_end` pulse placed in the middle of a fetch, and coincident start and end pulses, drive the phase decoder into its ignore and priority paths.

// File: rtl/pimg_pkg.sv
package pimg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_FLUSH = 2'd2
  } phase_t;
endpackage

// File: rtl/pimg_shadow.sv
// Local shadow store: one word and one modified flag per entry.
module pimg_shadow #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_we,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [DW-1:0]   fill_data,
  input  logic            clr_dirty,
  input  logic            cw_en,
  input  logic [IDXW-1:0] cw_idx,
  input  logic [DW-1:0]   cw_data,
  input  logic [IDXW-1:0] cr_idx,
  output logic [DW-1:0]   cr_data,
  output logic [DW-1:0]   seq_data,
  output logic            seq_dirty
);
  logic [DW-1:0]    val_q [DEPTH];
  logic [DEPTH-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) val_q[e] <= '0;
      dirty_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (fill_we && fill_idx == IDXW'(e))      val_q[e] <= fill_data;
        else if (cw_en && cw_idx == IDXW'(e))     val_q[e] <= cw_data;
        if (clr_dirty)                            dirty_q[e] <= 1'b0;
        else if (cw_en && cw_idx == IDXW'(e))     dirty_q[e] <= 1'b1;
      end
    end
  end

  assign cr_data   = val_q[cr_idx];
  assign seq_data  = val_q[fill_idx];
  assign seq_dirty = dirty_q[fill_idx];
endmodule

// File: rtl/pimg_seq.sv
// Phase sequencer: walks the window for copy-in and for write-back.
module pimg_seq
  import pimg_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_start,
  input  logic            cycle_end,
  input  logic            gm_ack,
  input  logic            cur_dirty,
  output logic [IDXW-1:0] idx,
  output logic            gm_req,
  output logic            gm_we,
  output logic            fill_we,
  output logic            clr_dirty,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  phase_t ph_q;
  logic   is_last;

  assign is_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx    <= '0;
      gm_req <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          idx <= '0;
          if (cycle_start) begin
            ph_q   <= PH_FETCH;
            gm_req <= 1'b1;
          end else if (cycle_end) begin
            ph_q <= PH_FLUSH;
          end
        end
        PH_FETCH: begin
          if (gm_req) begin
            if (gm_ack) begin
              gm_req <= 1'b0;
              if (is_last) begin
                ph_q <= PH_IDLE;
                done <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end else begin
            gm_req <= 1'b1;
          end
        end
        PH_FLUSH: begin
          if (gm_req) begin
            if (gm_ack) begin
              gm_req <= 1'b0;
              if (is_last) begin
                ph_q <= PH_IDLE;
                done <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end else if (cur_dirty) begin
            gm_req <= 1'b1;
          end else if (is_last) begin
            ph_q <= PH_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign gm_we     = (ph_q == PH_FLUSH);
  assign fill_we   = (ph_q == PH_FETCH) && gm_req && gm_ack;
  assign clr_dirty = fill_we && is_last;
endmodule

// File: rtl/pimg_sync.sv
// Process image synchronizer top.
module pimg_sync #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 16,
  parameter int unsigned GBASE = 'h100,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_start,
  input  logic            cycle_end,
  output logic            busy,
  output logic            done,
  input  logic            core_valid,
  output logic            core_ready,
  input  logic            core_we,
  input  logic [IDXW-1:0] core_idx,
  input  logic [DW-1:0]   core_wdata,
  output logic [DW-1:0]   core_rdata,
  output logic            gm_req,
  input  logic            gm_ack,
  output logic            gm_we,
  output logic [AW-1:0]   gm_addr,
  output logic [DW-1:0]   gm_wdata,
  input  logic [DW-1:0]   gm_rdata
);
  logic [IDXW-1:0] seq_idx;
  logic            fill_we, clr_dirty, cur_dirty, cw_en;

  assign core_ready = !busy;
  assign cw_en      = core_valid && core_ready && core_we;
  assign gm_addr    = AW'(GBASE) + AW'(seq_idx);

  pimg_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .cycle_end  (cycle_end),
    .gm_ack     (gm_ack),
    .cur_dirty  (cur_dirty),
    .idx        (seq_idx),
    .gm_req     (gm_req),
    .gm_we      (gm_we),
    .fill_we    (fill_we),
    .clr_dirty  (clr_dirty),
    .busy       (busy),
    .done       (done)
  );

  pimg_shadow #(.DEPTH(DEPTH), .DW(DW)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_we  (fill_we),
    .fill_idx (seq_idx),
    .fill_data(gm_rdata),
    .clr_dirty(clr_dirty),
    .cw_en    (cw_en),
    .cw_idx   (core_idx),
    .cw_data  (core_wdata),
    .cr_idx   (core_idx),
    .cr_data  (core_rdata),
    .seq_data (gm_wdata),
    .seq_dirty(cur_dirty)
  );
endmodule

// File: rtl/pimg_sync_chk.sv
module pimg_sync_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cycle_start,
  input logic          cycle_end,
  input logic          busy,
  input logic          done,
  input logic          gm_req,
  input logic          gm_ack,
  input logic          gm_we,
  input logic [AW-1:0] gm_addr,
  input logic [DW-1:0] gm_wdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gm_req && !gm_ack |=> gm_req);                                   // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    gm_req && !gm_ack |=> $stable(gm_addr) && $stable(gm_we) && $stable(gm_wdata)); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    gm_req && gm_ack |=> !gm_req);                                   // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                 // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                 // R4
  AST_REQ_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    gm_req |-> busy);                                                // R4
  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cycle_start |=> busy && !gm_we);                        // R2
  AST_END_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cycle_end && !cycle_start |=> busy && gm_we);           // R7
endmodule

bind pimg_sync pimg_sync_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cycle_start(cycle_start),
  .cycle_end  (cycle_end),
  .busy       (busy),
  .done       (done),
  .gm_req     (gm_req),
  .gm_ack     (gm_ack),
  .gm_we      (gm_we),
  .gm_addr    (gm_addr),
  .gm_wdata   (gm_wdata)
);

// File: tb/tb_pimg_sync.sv
module tb_pimg_sync;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int GBASE = 'h100;
  localparam int IDXW  = 4;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } xfer_t;

  logic clk = 0, rst_n = 0;
  logic cycle_start = 0, cycle_end = 0;
  logic busy, done, core_ready, gm_req, gm_we;
  logic core_valid = 0, core_we = 0;
  logic [IDXW-1:0] core_idx = '0;
  logic [DW-1:0] core_wdata = '0, core_rdata, gm_wdata;
  logic [DW-1:0] gm_rdata = '0;
  logic [AW-1:0] gm_addr;
  logic gm_ack = 0;

  logic [DW-1:0] gmem [DEPTH];
  xfer_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  logic [7:0] lfsr = 8'h5a;
  int wcnt = 0;

  always #4 clk = ~clk;

  pimg_sync #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .GBASE(GBASE)) dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cycle_end(cycle_end),
    .busy(busy), .done(done), .core_valid(core_valid), .core_ready(core_ready),
    .core_we(core_we), .core_idx(core_idx), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .gm_req(gm_req), .gm_ack(gm_ack), .gm_we(gm_we),
    .gm_addr(gm_addr), .gm_wdata(gm_wdata), .gm_rdata(gm_rdata));

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arbiter and global memory model with varying acknowledge delay
  always @(posedge clk) begin
    gm_ack <= 1'b0;
    if (gm_req && !gm_ack) begin
      if (wcnt >= int'(lfsr[1:0])) begin
        logic [IDXW-1:0] mi;
        mi = IDXW'(gm_addr - AW'(GBASE));
        gm_ack <= 1'b1;
        wcnt   <= 0;
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (gm_we) gmem[mi] <= gm_wdata;
        else       gm_rdata <= gmem[mi];
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // Monitor: compares each completed global transfer with the scoreboard
  always @(negedge clk) begin
    if (rst_n && gm_req && gm_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 R8 unexpected transfer", DW'(gm_addr), '0);
      end else begin
        xfer_t e;
        e = exp_q.pop_front();
        check(gm_we == e.we, "R2 R7 transfer direction", DW'(gm_we), DW'(e.we));
        check(gm_addr == e.addr, "R2 R7 transfer address", DW'(gm_addr), DW'(e.addr));
        if (e.we) check(gm_wdata == e.data, "R7 write-back data", gm_wdata, e.data);
      end
    end
  end

  task automatic push_fetch();
    for (int i = 0; i < DEPTH; i++) exp_q.push_back('{1'b0, AW'(GBASE + i), '0});
  endtask

  task automatic push_write(input int i, input logic [DW-1:0] d);
    exp_q.push_back('{1'b1, AW'(GBASE + i), d});
  endtask

  task automatic pulse(input bit s, input bit e);
    @(negedge clk); cycle_start = s; cycle_end = e;
    @(negedge clk); cycle_start = 0; cycle_end = 0;
  endtask

  task automatic wait_done(input string tag);
    while (!done) @(negedge clk);
    check(busy == 1'b0, {tag, " R4 busy low with done"}, DW'(busy), '0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R4 done one cycle"}, DW'(done), '0);
  endtask

  task automatic core_write(input int i, input logic [DW-1:0] d);
    core_valid = 1; core_we = 1; core_idx = IDXW'(i); core_wdata = d;
    #1;
    while (!core_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    core_valid = 0; core_we = 0;
  endtask

  task automatic core_read(input int i, output logic [DW-1:0] d);
    @(negedge clk);
    core_valid = 1; core_we = 0; core_idx = IDXW'(i);
    #1;
    while (!core_ready) begin @(negedge clk); #1; end
    d = core_rdata;
    @(negedge clk);
    core_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    bit quiet;
    for (int i = 0; i < DEPTH; i++) gmem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && gm_req == 0 && core_ready == 1,
          "R1 reset outputs", {busy, done, gm_req, core_ready}, 32'h1);
    rst_n = 1;

    // R2: full fetch in ascending order
    push_fetch();
    pulse(1, 0);
    check(busy == 1 && core_ready == 0, "R4 busy during fetch",
          {busy, core_ready}, 32'h2);
    wait_done("fetch1");
    check(exp_q.size() == 0, "R2 all entries fetched", exp_q.size(), 0);
    for (int i = 0; i < DEPTH; i++) begin
      core_read(i, rd);
      check(rd == 32'hA000_0000 + i, "R2 R5 fetched value", rd, 32'hA000_0000 + i);
    end

    // R6: global change mid-cycle is invisible
    gmem[3] = 32'h3333_3333;
    core_read(3, rd);
    check(rd == 32'hA000_0003, "R6 isolation from global change", rd, 32'hA000_0003);

    // R5 / R7: writes then selective write-back
    @(negedge clk);
    core_write(2, 32'h0000_0222);
    core_write(15, 32'h0000_0FFF);
    core_write(5, 32'h0000_0555);
    core_read(5, rd);
    check(rd == 32'h0000_0555, "R5 write then read", rd, 32'h0000_0555);
    push_write(2, 32'h0000_0222);
    push_write(5, 32'h0000_0555);
    push_write(15, 32'h0000_0FFF);
    pulse(0, 1);
    wait_done("flush1");
    check(exp_q.size() == 0, "R7 dirty entries written back", exp_q.size(), 0);
    check(gmem[5] == 32'h0000_0555, "R7 global updated", gmem[5], 32'h0000_0555);
    check(gmem[3] == 32'h3333_3333, "R7 clean entry untouched", gmem[3], 32'h3333_3333);

    // R9 / R8: refetch clears dirty; empty flush has no traffic
    push_fetch();
    pulse(1, 0);
    wait_done("fetch2");
    core_read(3, rd);
    check(rd == 32'h3333_3333, "R2 refetch sees new global", rd, 32'h3333_3333);
    pulse(0, 1);
    wait_done("flush2");
    check(exp_q.size() == 0, "R8 R9 no write-back after refetch", exp_q.size(), 0);

    // R11: write presented during fetch is stalled and survives
    push_fetch();
    pulse(1, 0);
    check(core_ready == 0, "R11 core held off during fetch", DW'(core_ready), '0);
    core_write(7, 32'hCAFE_0007);
    check(exp_q.size() == 0, "R11 fetch finished before write", exp_q.size(), 0);
    core_read(7, rd);
    check(rd == 32'hCAFE_0007, "R11 stalled write kept", rd, 32'hCAFE_0007);
    push_write(7, 32'hCAFE_0007);
    pulse(0, 1);
    wait_done("flush3");
    check(exp_q.size() == 0 && gmem[7] == 32'hCAFE_0007, "R9 R11 only entry 7 written",
          gmem[7], 32'hCAFE_0007);

    // R10: end pulse during fetch ignored
    push_fetch();
    pulse(1, 0);
    repeat (5) @(negedge clk);
    pulse(0, 1);
    wait_done("fetch4");
    quiet = 1;
    repeat (40) begin
      @(negedge clk);
      if (busy || gm_req) quiet = 0;
    end
    check(quiet, "R10 pulse during busy ignored", DW'(quiet), 32'h1);
    check(exp_q.size() == 0, "R10 fetch traffic complete", exp_q.size(), 0);

    // R10: simultaneous start and end while idle -> fetch only
    gmem[9] = 32'h9999_0009;
    push_fetch();
    pulse(1, 1);
    wait_done("fetch5");
    check(exp_q.size() == 0, "R10 start wins over end", exp_q.size(), 0);
    core_read(9, rd);
    check(rd == 32'h9999_0009, "R10 fetch result after both pulses", rd, 32'h9999_0009);
    repeat (20) @(negedge clk);
    check(busy == 0 && exp_q.size() == 0, "R10 no write-back followed", DW'(busy), '0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule